// File: doc/BRIEF.md
# Armed Double-Buffered Display Register Bank

This block keeps a small set of display configuration registers as two copies each: a pending copy that software writes and an active copy that drives the display datapath. A write never goes straight to the active copy. Writing the ordinary configuration registers only stages new values. Writing the trigger register, which plays the part of a surface-address register, arms the bank. While the bank is armed, the next vertical-blank start copies every pending value, the trigger included, into the active copies in a single cycle.

A pipe/plane enable pulse forces the same transfer at once, whether or not the bank is armed. A frame counter steps on every vertical-blank start. Software reads the counter before and after a commit and waits for the count to change. A second read-only address range returns the active values, the armed flag and the counter.

Top module: `armed_dbuf_bank`

## Requirements
- R1: A write to a configuration address (0 to NUM_REGS-1) updates only that pending copy. The active copies do not change in any cycle without a transfer.
- R2: A write to the trigger address (NUM_REGS-1, address 3 by default) sets the armed flag. The flag reads as bit 0 at status address WIN+NUM_REGS (12 by default) and is also driven on `armed`.
- R3: A vertical-blank start pulse while the bank is armed copies all pending values into the active copies. The armed flag clears in that same cycle.
- R4: A vertical-blank start pulse while the bank is not armed leaves the active copies unchanged.
- R5: An enable pulse copies all pending values into the active copies at once, whatever the armed state. The armed flag clears.
- R6: If a trigger write lands in a transfer cycle, the active copies receive the pending values from before that write, and the armed flag stays set for the next vertical blank.
- R7: A vertical-blank start and an enable pulse in the same cycle cause exactly one transfer, and the frame count advances by one.
- R8: The frame counter advances by one, modulo 2^FRAME_W, on each vertical-blank start. It reads at address WIN+NUM_REGS+1 (13 by default).
- R9: Reads at addresses 0 to NUM_REGS-1 return pending values. Reads at WIN+i (WIN = 8 by default) return active value i. Any other address reads zero. Writes at addresses NUM_REGS and above change no state.
- R10: Reset sets all pending copies, all active copies, the armed flag and the frame counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address (combinational read) |
| rd_data | output | DATA_W | Read data |
| vblank_start | input | 1 | Single-cycle pulse at vertical-blank start |
| plane_enable | input | 1 | Pulse while the pipe/plane is being enabled |
| active_flat | output | NUM_REGS*DATA_W | Active copies, register i at bits [i*DATA_W +: DATA_W] |
| armed | output | 1 | Armed flag |
| frame_count | output | FRAME_W | Frame counter |

## Verification
A stuck or mistimed armed flag shows up as active values that change one frame early or one frame late. This can be seen on `active_flat` and in the active read range in the cycle after the vertical-blank pulse. A transfer that picks up a same-cycle write shows the new value one frame too soon. A double transfer or a missed counter step shows as a frame count off by one at the next read. A pending copy corrupted by a write to an out-of-range address shows on the very next pending read.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    typedef enum logic [1:0] {
        RD_PENDING = 2'd0,
        RD_ACTIVE  = 2'd1,
        RD_STATUS  = 2'd2,
        RD_NONE    = 2'd3
    } rd_region_e;

    typedef struct packed {
        logic xfer;     // copy pending into active this cycle
        logic arm_set;  // trigger write seen this cycle
    } commit_t;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/dbuf_pending.sv
module dbuf_pending #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_hit,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] pending_flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= '0;
            else if (wr_hit && (wr_idx == IDX_W'(g)))
                val_q <= wr_data;
        end
        assign pending_flat[g*DATA_W +: DATA_W] = val_q;
    end
endmodule

// File: rtl/dbuf_arm_ctrl.sv
module dbuf_arm_ctrl
    import dbuf_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_wr,
    input  logic               vblank_start,
    input  logic               plane_enable,
    output commit_t            commit,
    output logic               armed,
    output logic [FRAME_W-1:0] frame_count
);
    logic armed_q;
    logic [FRAME_W-1:0] frame_q;

    always_comb begin
        commit.arm_set = trig_wr;
        commit.xfer    = plane_enable || (vblank_start && armed_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            frame_q <= '0;
        end else begin
            if (commit.arm_set)
                armed_q <= 1'b1;
            else if (commit.xfer)
                armed_q <= 1'b0;
            if (vblank_start)
                frame_q <= frame_q + 1'b1;
        end
    end

    assign armed       = armed_q;
    assign frame_count = frame_q;

    p_trig_arms_r2: assert property (@(posedge clk) disable iff (rst)
        trig_wr |=> armed);
    p_vbl_disarms_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && vblank_start && !trig_wr) |=> !armed);
    p_enable_disarms_r5: assert property (@(posedge clk) disable iff (rst)
        (plane_enable && !trig_wr) |=> !armed);
    p_frame_step_r8: assert property (@(posedge clk) disable iff (rst)
        vblank_start |=> frame_count == $past(frame_count) + 1'b1);
    p_frame_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !vblank_start |=> $stable(frame_count));
endmodule

// File: rtl/dbuf_active.sv
module dbuf_active #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       xfer,
    input  logic [NUM_REGS*DATA_W-1:0] pending_flat,
    output logic [NUM_REGS*DATA_W-1:0] active_flat
);
    logic [NUM_REGS*DATA_W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= '0;
        else if (xfer)
            active_q <= pending_flat;
    end

    assign active_flat = active_q;

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(active_flat));
    p_copy_r3: assert property (@(posedge clk) disable iff (rst)
        xfer |=> active_flat == $past(pending_flat));
endmodule

// File: rtl/armed_dbuf_bank.sv
module armed_dbuf_bank
    import dbuf_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int FRAME_W  = 16,
    localparam int IDX_W   = idx_bits(NUM_REGS + 2),
    localparam int ADDR_W  = IDX_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    input  logic                       vblank_start,
    input  logic                       plane_enable,
    output logic [NUM_REGS*DATA_W-1:0] active_flat,
    output logic                       armed,
    output logic [FRAME_W-1:0]         frame_count
);
    localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(NUM_REGS - 1);
    localparam logic [IDX_W-1:0]  STAT_IDX  = IDX_W'(NUM_REGS);
    localparam logic [IDX_W-1:0]  FRAME_IDX = IDX_W'(NUM_REGS + 1);

    logic                       wr_hit;
    logic                       trig_wr;
    commit_t                    commit;
    logic [NUM_REGS*DATA_W-1:0] pending_flat;
    rd_region_e                 region;
    logic [IDX_W-1:0]           rd_idx;

    assign wr_hit  = wr_en && (wr_addr < ADDR_W'(NUM_REGS));
    assign trig_wr = wr_en && (wr_addr == TRIG_ADDR);
    assign rd_idx  = rd_addr[IDX_W-1:0];

    dbuf_pending #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_pending (
        .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_idx(wr_addr[IDX_W-1:0]),
        .wr_data(wr_data), .pending_flat(pending_flat)
    );

    dbuf_arm_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
        .clk(clk), .rst(rst), .trig_wr(trig_wr), .vblank_start(vblank_start),
        .plane_enable(plane_enable), .commit(commit), .armed(armed),
        .frame_count(frame_count)
    );

    dbuf_active #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_active (
        .clk(clk), .rst(rst), .xfer(commit.xfer),
        .pending_flat(pending_flat), .active_flat(active_flat)
    );

    always_comb begin
        if (!rd_addr[ADDR_W-1])
            region = (rd_idx < IDX_W'(NUM_REGS)) ? RD_PENDING : RD_NONE;
        else if (rd_idx < IDX_W'(NUM_REGS))
            region = RD_ACTIVE;
        else if (rd_idx == STAT_IDX || rd_idx == FRAME_IDX)
            region = RD_STATUS;
        else
            region = RD_NONE;
    end

    always_comb begin
        rd_data = '0;
        unique case (region)
            RD_PENDING: for (int i = 0; i < NUM_REGS; i++)
                            if (rd_idx == IDX_W'(i)) rd_data = pending_flat[i*DATA_W +: DATA_W];
            RD_ACTIVE:  for (int i = 0; i < NUM_REGS; i++)
                            if (rd_idx == IDX_W'(i)) rd_data = active_flat[i*DATA_W +: DATA_W];
            RD_STATUS:  rd_data = (rd_idx == STAT_IDX) ? DATA_W'(armed) : DATA_W'(frame_count);
            default:    rd_data = '0;
        endcase
    end

    p_oob_write_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= ADDR_W'(NUM_REGS) && !vblank_start && !plane_enable)
        |=> $stable(pending_flat) && $stable(active_flat));
    p_unarmed_vbl_r4: assert property (@(posedge clk) disable iff (rst)
        (!armed && vblank_start && !plane_enable) |=> $stable(active_flat));
endmodule

// File: tb/armed_dbuf_bank_tb.sv
module armed_dbuf_bank_tb;
    localparam int NR = 4, DW = 32, FW = 16, AW = 4;
    localparam int WIN = 8, TRIG = NR - 1, STAT = WIN + NR, FRM = WIN + NR + 1;

    logic clk = 0, rst = 1, wr_en = 0, vbl = 0, en = 0;
    logic [AW-1:0] wr_addr = 0, rd_addr = 0;
    logic [DW-1:0] wr_data = 0, rd_data;
    logic [NR*DW-1:0] active_flat;
    logic armed;
    logic [FW-1:0] frame_count;

    always #4 clk = ~clk;

    armed_dbuf_bank #(.NUM_REGS(NR), .DATA_W(DW), .FRAME_W(FW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .vblank_start(vbl), .plane_enable(en),
        .active_flat(active_flat), .armed(armed), .frame_count(frame_count)
    );

    typedef struct { logic [DW-1:0] exp; string tag; } item_t;
    item_t q[$];
    int tests = 0, fails = 0;

    logic [DW-1:0] pend_m [NR];
    logic [DW-1:0] act_m  [NR];
    logic armed_m;
    logic [FW-1:0] frame_m;

    // monitor: pops expectations and compares with the read port
    always @(posedge clk) begin
        if (q.size() != 0) begin
            item_t it;
            #1;
            it = q.pop_front();
            tests++;
            if (rd_data !== it.exp) begin
                fails++;
                $display("FAIL %s: rd_data=%h expected=%h", it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic expect_rd(input int a, input logic [DW-1:0] e, input string tag);
        item_t it;
        @(negedge clk);
        rd_addr = AW'(a);
        it.exp = e; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #2;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NR; i++) expect_rd(i, pend_m[i], {tag, " pending"});
        for (int i = 0; i < NR; i++) expect_rd(WIN + i, act_m[i], {tag, " active"});
        expect_rd(STAT, DW'(armed_m), {tag, " armed"});
        expect_rd(FRM, DW'(frame_m), {tag, " frame"});
        @(negedge clk);
        for (int i = 0; i < NR; i++) begin
            tests++;
            if (active_flat[i*DW +: DW] !== act_m[i]) begin
                fails++;
                $display("FAIL %s port active[%0d]=%h expected=%h", tag, i,
                         active_flat[i*DW +: DW], act_m[i]);
            end
        end
    endtask

    // one stimulus cycle; model follows the requirements
    task automatic step(input logic we, input int a, input logic [DW-1:0] d,
                        input logic vb, input logic pe);
        logic xfer;
        @(negedge clk);
        wr_en = we; wr_addr = AW'(a); wr_data = d; vbl = vb; en = pe;
        @(negedge clk);
        wr_en = 0; vbl = 0; en = 0;
        xfer = pe || (vb && armed_m);                      // R3 R4 R5 R7
        if (xfer) for (int i = 0; i < NR; i++) act_m[i] = pend_m[i];   // R6: old pending
        if (we && a == TRIG) armed_m = 1'b1;               // R2 R6
        else if (xfer) armed_m = 1'b0;
        if (we && a < NR) pend_m[a] = d;                   // R1 R9
        if (vb) frame_m = frame_m + 1'b1;                  // R8 R7
    endtask

    initial begin
        #(8 * 200000);
        fails++; tests++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) begin pend_m[i] = 0; act_m[i] = 0; end
        armed_m = 0; frame_m = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check_all("R10 reset");

        step(1, 0, 32'hA1A1_0001, 0, 0);
        step(1, 1, 32'hB2B2_0002, 0, 0);
        check_all("R1 staged writes");

        step(0, 0, 0, 1, 0);
        check_all("R4 unarmed vblank / R8 frame");

        step(1, TRIG, 32'h5000_1000, 0, 0);
        check_all("R2 trigger arms");

        step(1, 2, 32'hC3C3_0003, 0, 0);
        step(0, 0, 0, 1, 0);
        check_all("R3 armed vblank transfer");

        step(1, 0, 32'hD4D4_0004, 0, 0);
        step(0, 0, 0, 0, 1);
        check_all("R5 enable unarmed transfer");

        step(1, 1, 32'hE5E5_0005, 0, 0);
        step(1, TRIG, 32'h5000_2000, 0, 0);
        step(1, TRIG, 32'h5000_3000, 1, 0);
        check_all("R6 trigger in transfer cycle");

        step(0, 0, 0, 1, 0);
        check_all("R6 rearmed next vblank");

        step(1, 2, 32'hF6F6_0006, 0, 0);
        step(1, TRIG, 32'h5000_4000, 0, 0);
        step(0, 0, 0, 1, 1);
        check_all("R7 vblank with enable");

        step(1, 4, 32'hDEAD_BEEF, 0, 0);
        step(1, 7, 32'hDEAD_BEEF, 0, 0);
        step(1, WIN, 32'hDEAD_BEEF, 0, 0);
        step(1, FRM, 32'hDEAD_BEEF, 0, 0);
        check_all("R9 out-of-range writes ignored");
        expect_rd(WIN + NR + 2, 0, "R9 unmapped read");
        expect_rd(NR, 0, "R9 unmapped low read");

        step(1, 0, 32'h1111_2222, 0, 0);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        for (int i = 0; i < NR; i++) begin pend_m[i] = 0; act_m[i] = 0; end
        armed_m = 0; frame_m = 0;
        check_all("R10 reset after traffic");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule